// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits on the CPU side of a host-to-PCI bridge. It decides whether a CPU memory address should be forwarded to the PCI bus. The top 256 MiB of the address space (tag nibble 0xF) is split into 32 chunks of 8 MiB each. A 32-bit window-enable register holds one enable bit per chunk. A two-bit forwarding mode field inside a control word gates every window at once.

The two chunks at the ends of that region are never forwarded, whatever their enable bits hold. These are chunk 0, which holds the firmware, and chunk 31, which holds the bridge's own registers.

Software writes and reads both registers through a simple write strobe and a combinational read port. Each lookup request gets a registered answer: a hit flag and the index of the chunk that was addressed. The block also exposes the current set of active windows as a 32-bit vector, so that neighbouring logic can follow it.

Top module: `outbound_window_decoder`

## Requirements
- R1: After a synchronous reset, both registers read back as zero. The active vector is zero, `fwd_valid` and `fwd_hit` are low, and `fwd_chunk` is zero.
- R2: A write with `cfg_wr_sel`=0 loads the window-enable register, and a write with `cfg_wr_sel`=1 loads the control word. All 32 bits are stored. `cfg_rd_data` returns the register chosen by `cfg_rd_sel` (same encoding), combinationally.
- R3: Forwarding is enabled only while control word bits [8:7] equal binary 01. The values 00, 10 and 11 turn every window off, and no request hits.
- R4: A request hits when all of the following are true: address bits [31:28] equal 0xF, the chunk index addr[27:23] lies in 1..30, the enable bit at that index is 1, and the mode is 01.
- R5: Chunk 0 (0xF0000000..0xF07FFFFF) and chunk 31 (0xFF800000..0xFFFFFFFF) never hit, even with their enable bits set and the mode on.
- R6: An address whose bits [31:28] are not 0xF never hits, and its reported chunk index is 0. For an address in the 0xF region, the reported index is addr[27:23] whether or not it hits.
- R7: `fwd_valid` pulses high in the cycle after each cycle in which `req_valid` is high, so back-to-back requests give back-to-back results. `fwd_hit` and `fwd_chunk` keep their last values while no request is presented.
- R8: A register write takes effect for any request presented in the next cycle or later. A request presented in the same cycle as the write is judged against the old register values.
- R9: `active_mask` bit i is 1 exactly when i is in 1..30, enable bit i is 1 and the mode is 01. The vector follows every write to either register one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 window-enable, 1 control word |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 1 | Readback select: 0 window-enable, 1 control word |
| cfg_rd_data | output | 32 | Readback data (combinational) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | CPU address to classify |
| fwd_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| fwd_hit | output | 1 | Address is forwarded to PCI |
| fwd_chunk | output | 5 | Chunk index of the last request |
| active_mask | output | 32 | Currently forwardable chunks |

## Verification
Lookup results are due one clock after the request. Each request therefore pushes its expected hit and index into a queue, and a monitor pops one entry on every falling edge where `fwd_valid` is high, so each result is compared in the cycle it appears. Readback is combinational and is checked a moment after the read select changes. `active_mask` changes one edge after a write, so it is checked after the write task has passed that edge. The same-cycle write-and-request case is modelled with the pre-write register values, which fixes the exact cycle at which a write first matters.

// File: rtl/odec_pkg.sv
package odec_pkg;

    localparam int ADDR_W     = 32;
    localparam int IDX_W      = 5;
    localparam int CHUNKS     = 1 << IDX_W;
    localparam int CHUNK_LSB  = 23;
    localparam int TAG_W      = ADDR_W - CHUNK_LSB - IDX_W;
    localparam int MODE_W     = 2;
    localparam int MODE_LSB   = 7;
    localparam logic [MODE_W-1:0] MODE_FWD = 2'b01;
    localparam logic [TAG_W-1:0]  REGION_TAG = '1;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_CTRL   = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] chunk;
    } fwd_result_t;

    // Chunk indices at both ends of the region are reserved.
    function automatic logic chunk_reserved(input int idx);
        return (idx == 0) || (idx == CHUNKS - 1);
    endfunction

endpackage

// File: rtl/odec_cfg_regs.sv
module odec_cfg_regs
    import odec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  cfg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  cfg_sel_e          rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] enable_q,
    output logic [DATA_W-1:0] ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_ENABLE) begin
                enable_q <= wr_data;
            end else begin
                ctrl_q <= wr_data;
            end
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_ENABLE: rd_data = enable_q;
            SEL_CTRL:   rd_data = ctrl_q;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/odec_window_mask.sv
module odec_window_mask
    import odec_pkg::*;
#(
    parameter int                 N_CHUNKS = CHUNKS,
    parameter int                 M_W      = MODE_W,
    parameter logic [M_W-1:0]     M_ON     = MODE_FWD
) (
    input  logic [N_CHUNKS-1:0] enable_bits,
    input  logic [M_W-1:0]      mode,
    output logic [N_CHUNKS-1:0] active
);

    logic gate_on;
    assign gate_on = (mode == M_ON);

    for (genvar g = 0; g < N_CHUNKS; g++) begin : g_win
        if (g == 0 || g == N_CHUNKS - 1) begin : g_fixed_off
            logic unused_en;
            assign unused_en = enable_bits[g];
            assign active[g] = 1'b0;
        end else begin : g_gated
            assign active[g] = enable_bits[g] & gate_on;
        end
    end

endmodule

// File: rtl/odec_lookup.sv
module odec_lookup
    import odec_pkg::*;
#(
    parameter int               I_W = IDX_W,
    parameter int               T_W = TAG_W,
    parameter logic [T_W-1:0]   TAG = REGION_TAG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [T_W+I_W-1:0]  req_upper,
    input  logic [(1<<I_W)-1:0] active,
    output logic                res_valid,
    output fwd_result_t         res
);

    logic [T_W-1:0] tag;
    logic           in_region;
    fwd_result_t    res_next;

    assign tag = req_upper[T_W+I_W-1 -: T_W];

    always_comb begin
        in_region      = (tag == TAG);
        res_next.chunk = in_region ? req_upper[I_W-1:0] : '0;
        res_next.hit   = in_region && active[res_next.chunk];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res <= res_next;
            end
        end
    end

endmodule

// File: rtl/outbound_window_decoder.sv
module outbound_window_decoder
    import odec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic              cfg_rd_sel,
    output logic [ADDR_W-1:0] cfg_rd_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              fwd_valid,
    output logic              fwd_hit,
    output logic [IDX_W-1:0]  fwd_chunk,
    output logic [CHUNKS-1:0] active_mask
);

    logic [ADDR_W-1:0] enable_word;
    logic [ADDR_W-1:0] ctrl_word;
    fwd_result_t       result;
    logic              unused_low;

    assign unused_low = &{1'b0, req_addr[CHUNK_LSB-1:0],
                          ctrl_word[ADDR_W-1:MODE_LSB+MODE_W],
                          ctrl_word[MODE_LSB-1:0]};

    odec_cfg_regs #(.DATA_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_sel_e'(cfg_wr_sel)),
        .wr_data  (cfg_wr_data),
        .rd_sel   (cfg_sel_e'(cfg_rd_sel)),
        .rd_data  (cfg_rd_data),
        .enable_q (enable_word),
        .ctrl_q   (ctrl_word)
    );

    odec_window_mask u_mask (
        .enable_bits (enable_word[CHUNKS-1:0]),
        .mode        (ctrl_word[MODE_LSB +: MODE_W]),
        .active      (active_mask)
    );

    odec_lookup u_lookup (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_upper (req_addr[ADDR_W-1:CHUNK_LSB]),
        .active    (active_mask),
        .res_valid (fwd_valid),
        .res       (result)
    );

    assign fwd_hit   = result.hit;
    assign fwd_chunk = result.chunk;

endmodule

// File: rtl/odec_checker.sv
module odec_checker
    import odec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [TAG_W-1:0]  req_tag,
    input logic [MODE_W-1:0] mode,
    input logic              fwd_valid,
    input logic              fwd_hit,
    input logic [IDX_W-1:0]  fwd_chunk,
    input logic [CHUNKS-1:0] active_mask
);

    logic [CHUNKS-1:0] mask_d;
    always_ff @(posedge clk) begin
        if (rst) mask_d <= '0;
        else     mask_d <= active_mask;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (active_mask == '0 && !fwd_valid && !fwd_hit && fwd_chunk == '0));

    a_r3_mode_off_no_window: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_FWD) |-> (active_mask == '0));

    a_r5_end_chunks_off: assert property (@(posedge clk) disable iff (rst)
        !active_mask[0] && !active_mask[CHUNKS-1]);

    a_r6_outside_region_miss: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_tag != REGION_TAG) |=> (!fwd_hit && fwd_chunk == '0));

    a_r7_result_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> fwd_valid);

    a_r7_no_spurious_result: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !fwd_valid);

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(fwd_hit) && $stable(fwd_chunk)));

    a_r4_hit_needs_window: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && fwd_hit) |-> mask_d[fwd_chunk]);

endmodule

bind outbound_window_decoder odec_checker u_odec_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_tag     (req_addr[odec_pkg::ADDR_W-1 -: odec_pkg::TAG_W]),
    .mode        (ctrl_word[odec_pkg::MODE_LSB +: odec_pkg::MODE_W]),
    .fwd_valid   (fwd_valid),
    .fwd_hit     (fwd_hit),
    .fwd_chunk   (fwd_chunk),
    .active_mask (active_mask)
);

// File: tb/test_outbound_window_decoder.sv
module test_outbound_window_decoder;

    localparam int  CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_rd_sel = 1'b0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        fwd_valid;
    logic        fwd_hit;
    logic [4:0]  fwd_chunk;
    logic [31:0] active_mask;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [31:0] m_en = '0;
    logic [31:0] m_ctrl = '0;
    logic [5:0]  exp_q[$];
    logic        last_hit = 1'b0;
    logic [4:0]  last_chunk = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    outbound_window_decoder i_outbound_window_decoder (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_addr(req_addr),
        .fwd_valid(fwd_valid), .fwd_hit(fwd_hit), .fwd_chunk(fwd_chunk),
        .active_mask(active_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] model(input logic [31:0] a);
        logic [4:0] idx;
        logic       in_r;
        logic       hit;
        in_r = (a[31:28] == 4'hF);
        idx  = in_r ? a[27:23] : 5'd0;
        hit  = in_r && (m_ctrl[8:7] == 2'b01) && idx != 0 && idx != 31 && m_en[idx];
        return {hit, idx};
    endfunction

    function automatic logic [31:0] model_mask();
        logic [31:0] m;
        m = (m_ctrl[8:7] == 2'b01) ? m_en : 32'h0;
        m[0] = 1'b0;
        m[31] = 1'b0;
        return m;
    endfunction

    // Monitor: pops one expectation per result strobe (R7 timing).
    always @(negedge clk) begin
        if (!rst && fwd_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected result", 32'(fwd_valid), 32'h0);
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                check("R4 hit", 32'(fwd_hit), 32'(e[5]));
                check("R6 chunk", 32'(fwd_chunk), 32'(e[4:0]));
                last_hit   = e[5];
                last_chunk = e[4:0];
            end
        end
    end

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (sel) m_ctrl = d; else m_en = d;
    endtask

    task automatic send(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        exp_q.push_back(model(a));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic readback(input logic sel, input logic [31:0] exp, input string req);
        cfg_rd_sel = sel;
        #1;
        check(req, cfg_rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        readback(1'b0, 32'h0, "R1 enable reset");
        readback(1'b1, 32'h0, "R1 ctrl reset");
        check("R1 mask reset", active_mask, 32'h0);
        check("R1 valid reset", 32'(fwd_valid), 32'h0);
        check("R1 hit reset", 32'(fwd_hit), 32'h0);
        check("R1 chunk reset", 32'(fwd_chunk), 32'h0);

        // R2 readback, R3 gate off with mode 00
        wr(1'b0, 32'hFFFF_FFFF);
        readback(1'b0, 32'hFFFF_FFFF, "R2 enable readback");
        check("R3 mode 00 mask", active_mask, 32'h0);
        send(32'hF100_0000); idle(2);
        wr(1'b1, 32'h0000_0100);
        readback(1'b1, 32'h0000_0100, "R2 ctrl readback");
        check("R3 mode 10 mask", active_mask, 32'h0);
        send(32'hF100_0000); idle(2);
        wr(1'b1, 32'h0000_0180);
        send(32'hF100_0000); idle(2);
        check("R3 mode 11 mask", active_mask, 32'h0);

        // R4 / R9 mode 01 enables
        wr(1'b1, 32'h0000_0080);
        check("R9 mask all", active_mask, model_mask());
        check("R9 mask value", active_mask, 32'h7FFF_FFFE);
        send(32'hF100_0000);
        send(32'hF080_0000);
        send(32'hFF7F_FFFF);
        // R5 end chunks
        send(32'hF000_0000);
        send(32'hF07F_FFFF);
        send(32'hFF80_0000);
        send(32'hFFFF_FFFF);
        // R6 outside region
        send(32'hEFFF_FFFF);
        send(32'h0000_0000);
        send(32'h7F80_0000);
        idle(2);

        // Sparse enable with other control bits set
        wr(1'b0, 32'h8000_0AAB);
        wr(1'b1, 32'hFFFF_FEFF);
        check("R9 mask sparse", active_mask, model_mask());
        for (int c = 0; c < 32; c++) send({4'hF, 5'(c), 23'h12345});
        idle(2);

        // R8 same-cycle write uses old value
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = 32'h0;
        req_valid = 1'b1; req_addr = 32'hF080_0000;
        exp_q.push_back(model(32'hF080_0000));
        @(negedge clk);
        cfg_wr_en = 1'b0; m_en = 32'h0;
        req_valid = 1'b1; req_addr = 32'hF080_0000;
        exp_q.push_back(model(32'hF080_0000));
        idle(1);
        check("R8 mask after write", active_mask, 32'h0);

        // R7 hold while idle
        wr(1'b0, 32'h0000_0400);
        send(32'hF500_0000); idle(4);
        check("R7 hold hit", 32'(fwd_hit), 32'(last_hit));
        check("R7 hold chunk", 32'(fwd_chunk), 32'(last_chunk));
        check("R7 hold value", {26'h0, fwd_hit, fwd_chunk}, {26'h0, 1'b1, 5'd10});
        check("R7 no strobe", 32'(fwd_valid), 32'h0);

        idle(2);
        check("R7 queue drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule